// File: doc/BRIEF.md
# Native display timing selector

This block watches a stream of already decoded detailed-timing descriptors and keeps the one with the largest horizontal active width. That one is taken as the display's native mode. Each beat carries a signed pixel clock, horizontal and vertical active, blanking, sync offset and sync width, a sync-kind code, two polarity bits and an interlace bit. For the kept descriptor the block registers the display, sync-start, sync-end and total counts of each axis, the pixel clock scaled by ten, and the positive-sync and interlace flags.

A one-cycle `start` pulse opens a selection and clears the kept mode. Descriptors then arrive on a valid/ready interface. `d_ready` is low only in the cycle `start` is high, so a beat offered in that cycle is held off and must stay valid until it is accepted. A beat counts when `d_valid` and `d_ready` are both high. The beat that carries `d_last` closes the stream. One cycle after that beat, `done` pulses together with either `result_valid` or `error`. The mode outputs hold their values until the next `start`.

Top module: `native_mode_pick`

## Requirements
- R1: An accepted beat whose pixel clock, read as a signed number, is zero or negative never becomes the kept mode and leaves all mode outputs unchanged.
- R2: An accepted beat with a positive clock replaces the kept mode only when its horizontal active width is strictly greater than the kept width. An equal or smaller width leaves the kept mode in place, whatever the vertical size.
- R3: For each axis of the kept mode: display equals active; sync start equals active plus sync offset; sync end equals sync start plus sync width; total equals active plus blanking.
- R4: `m_pclk` equals the kept descriptor's pixel clock multiplied by 10.
- R5: When the kept descriptor's sync kind equals 3, `m_pos_h` equals its polarity bit 0 and `m_pos_v` equals its polarity bit 1. For any other sync kind both flags are 0.
- R6: `m_ilace` equals the interlace bit of the kept descriptor.
- R7: In the cycle after the accepted beat that carries `d_last`, `done` is 1 for one cycle. In that cycle exactly one of `result_valid` and `error` is 1. `result_valid` is 1 only when a mode was kept and that mode is at least 640 wide and at least 480 high. Outside `done`, both are 0.
- R8: While `start` is 1, `d_ready` is 0. In the cycle after `start`, every mode output is 0.
- R9: After reset, `d_ready` is 1, and `done`, `result_valid`, `error` and all mode outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a new selection and clears the kept mode |
| d_valid | input | 1 | Descriptor beat offered |
| d_ready | output | 1 | Beat can be accepted (low during start) |
| d_last | input | 1 | Beat is the final one of the stream |
| d_pclk | input | PCLK_W | Signed pixel clock of the descriptor |
| d_h_act | input | ACT_W | Horizontal active |
| d_h_blank | input | BLK_W | Horizontal blanking |
| d_h_soff | input | OFF_W | Horizontal sync offset |
| d_h_swid | input | SWID_W | Horizontal sync width |
| d_v_act | input | ACT_W | Vertical active |
| d_v_blank | input | BLK_W | Vertical blanking |
| d_v_soff | input | OFF_W | Vertical sync offset |
| d_v_swid | input | SWID_W | Vertical sync width |
| d_sync_kind | input | SYNC_W | Sync kind code |
| d_misc | input | 2 | Polarity bits: bit 0 horizontal, bit 1 vertical |
| d_ilace | input | 1 | Interlaced descriptor |
| m_pclk | output | PCLK_W+4 | Kept pixel clock times 10 |
| m_h_disp | output | ACT_W+2 | Horizontal display count |
| m_h_ss | output | ACT_W+2 | Horizontal sync start |
| m_h_se | output | ACT_W+2 | Horizontal sync end |
| m_h_tot | output | ACT_W+2 | Horizontal total |
| m_v_disp | output | ACT_W+2 | Vertical display count |
| m_v_ss | output | ACT_W+2 | Vertical sync start |
| m_v_se | output | ACT_W+2 | Vertical sync end |
| m_v_tot | output | ACT_W+2 | Vertical total |
| m_pos_h | output | 1 | Positive horizontal sync |
| m_pos_v | output | 1 | Positive vertical sync |
| m_ilace | output | 1 | Interlaced mode |
| done | output | 1 | End-of-stream verdict pulse |
| result_valid | output | 1 | Kept mode usable |
| error | output | 1 | No usable mode |

## Verification
The bench sends streams of rising widths to show that the latest wider beat wins. Streams that repeat a width with a different height separate the strict comparison from a greater-or-equal one, and a smaller width that comes later shows it does not displace the kept mode. Wide beats with zero or negative clocks test the skip rule. A stream with only skipped beats, and modes of 600x480, 640x479 and exactly 640x480, exercise each side of the usability check. Sync kinds 3 and 2 with every polarity bit set are contrasted to show that polarity depends on the sync kind, and a clock of 32767 checks that the scaled clock does not overflow.

// File: rtl/nmp_pkg.sv
package nmp_pkg;
  // sync kind code for which the polarity bits are honoured
  localparam int unsigned POL_SYNC_CODE = 3;

  typedef struct packed {
    logic pos_h;
    logic pos_v;
    logic ilace;
  } mode_flags_t;
endpackage

// File: rtl/nmp_axis.sv
module nmp_axis #(
  parameter int ACT_W  = 12,
  parameter int BLK_W  = 12,
  parameter int OFF_W  = 10,
  parameter int SWID_W = 10,
  parameter int SPAN_W = ACT_W + 2
) (
  input  logic [ACT_W-1:0]  act,
  input  logic [BLK_W-1:0]  blank,
  input  logic [OFF_W-1:0]  soff,
  input  logic [SWID_W-1:0] swid,
  output logic [SPAN_W-1:0] disp,
  output logic [SPAN_W-1:0] sstart,
  output logic [SPAN_W-1:0] send,
  output logic [SPAN_W-1:0] total
);
  always_comb begin
    disp   = SPAN_W'(act);
    sstart = SPAN_W'(act) + SPAN_W'(soff);
    send   = sstart + SPAN_W'(swid);
    total  = SPAN_W'(act) + SPAN_W'(blank);
  end
endmodule

// File: rtl/nmp_flags.sv
module nmp_flags #(
  parameter int SYNC_W = 2
) (
  input  logic [SYNC_W-1:0]   sync_kind,
  input  logic [1:0]          misc,
  input  logic                ilace,
  output nmp_pkg::mode_flags_t flags
);
  logic pol_honoured;
  assign pol_honoured = (sync_kind == SYNC_W'(nmp_pkg::POL_SYNC_CODE));

  always_comb begin
    flags.pos_h = pol_honoured & misc[0];
    flags.pos_v = pol_honoured & misc[1];
    flags.ilace = ilace;
  end
endmodule

// File: rtl/nmp_judge.sv
module nmp_judge #(
  parameter int SPAN_W = 14,
  parameter int MIN_H  = 640,
  parameter int MIN_V  = 480
) (
  input  logic [SPAN_W-1:0] h_disp,
  input  logic [SPAN_W-1:0] v_disp,
  output logic              usable
);
  logic kept;
  assign kept   = (h_disp != '0);
  assign usable = kept && (h_disp >= SPAN_W'(MIN_H)) && (v_disp >= SPAN_W'(MIN_V));
endmodule

// File: rtl/native_mode_pick.sv
module native_mode_pick #(
  parameter int ACT_W      = 12,
  parameter int BLK_W      = 12,
  parameter int OFF_W      = 10,
  parameter int SWID_W     = 10,
  parameter int PCLK_W     = 16,
  parameter int SYNC_W     = 2,
  parameter int MIN_H      = 640,
  parameter int MIN_V      = 480,
  parameter int PCLK_SCALE = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     d_valid,
  output logic                     d_ready,
  input  logic                     d_last,
  input  logic signed [PCLK_W-1:0] d_pclk,
  input  logic [ACT_W-1:0]         d_h_act,
  input  logic [BLK_W-1:0]         d_h_blank,
  input  logic [OFF_W-1:0]         d_h_soff,
  input  logic [SWID_W-1:0]        d_h_swid,
  input  logic [ACT_W-1:0]         d_v_act,
  input  logic [BLK_W-1:0]         d_v_blank,
  input  logic [OFF_W-1:0]         d_v_soff,
  input  logic [SWID_W-1:0]        d_v_swid,
  input  logic [SYNC_W-1:0]        d_sync_kind,
  input  logic [1:0]               d_misc,
  input  logic                     d_ilace,
  output logic [PCLK_W+3:0]        m_pclk,
  output logic [ACT_W+1:0]         m_h_disp,
  output logic [ACT_W+1:0]         m_h_ss,
  output logic [ACT_W+1:0]         m_h_se,
  output logic [ACT_W+1:0]         m_h_tot,
  output logic [ACT_W+1:0]         m_v_disp,
  output logic [ACT_W+1:0]         m_v_ss,
  output logic [ACT_W+1:0]         m_v_se,
  output logic [ACT_W+1:0]         m_v_tot,
  output logic                     m_pos_h,
  output logic                     m_pos_v,
  output logic                     m_ilace,
  output logic                     done,
  output logic                     result_valid,
  output logic                     error
);
  localparam int SPAN_W     = ACT_W + 2;
  localparam int PCLK_OUT_W = PCLK_W + 4;
  localparam int N_AXIS     = 2;

  // per-axis descriptor fields, index 0 horizontal, 1 vertical
  logic [ACT_W-1:0]  ax_act   [N_AXIS];
  logic [BLK_W-1:0]  ax_blank [N_AXIS];
  logic [OFF_W-1:0]  ax_soff  [N_AXIS];
  logic [SWID_W-1:0] ax_swid  [N_AXIS];
  logic [SPAN_W-1:0] ax_disp  [N_AXIS];
  logic [SPAN_W-1:0] ax_ss    [N_AXIS];
  logic [SPAN_W-1:0] ax_se    [N_AXIS];
  logic [SPAN_W-1:0] ax_tot   [N_AXIS];

  assign ax_act[0]   = d_h_act;
  assign ax_blank[0] = d_h_blank;
  assign ax_soff[0]  = d_h_soff;
  assign ax_swid[0]  = d_h_swid;
  assign ax_act[1]   = d_v_act;
  assign ax_blank[1] = d_v_blank;
  assign ax_soff[1]  = d_v_soff;
  assign ax_swid[1]  = d_v_swid;

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    nmp_axis #(
      .ACT_W (ACT_W),
      .BLK_W (BLK_W),
      .OFF_W (OFF_W),
      .SWID_W(SWID_W),
      .SPAN_W(SPAN_W)
    ) u_axis (
      .act   (ax_act[a]),
      .blank (ax_blank[a]),
      .soff  (ax_soff[a]),
      .swid  (ax_swid[a]),
      .disp  (ax_disp[a]),
      .sstart(ax_ss[a]),
      .send  (ax_se[a]),
      .total (ax_tot[a])
    );
  end

  nmp_pkg::mode_flags_t cand_flags;

  nmp_flags #(.SYNC_W(SYNC_W)) u_flags (
    .sync_kind(d_sync_kind),
    .misc     (d_misc),
    .ilace    (d_ilace),
    .flags    (cand_flags)
  );

  // handshake and candidate selection
  logic beat, clock_ok, wider, take;
  assign d_ready  = !start;
  assign beat     = d_valid && d_ready;
  assign clock_ok = (d_pclk > 0);
  assign wider    = (ax_disp[0] > m_h_disp);
  assign take     = beat && clock_ok && wider;

  logic [PCLK_OUT_W-1:0] pclk_scaled;
  assign pclk_scaled = PCLK_OUT_W'($unsigned(d_pclk)) * PCLK_OUT_W'(PCLK_SCALE);

  // verdict uses the kept size as it will stand after this beat
  logic [SPAN_W-1:0] nxt_h_disp, nxt_v_disp;
  logic              nxt_usable;
  assign nxt_h_disp = take ? ax_disp[0] : m_h_disp;
  assign nxt_v_disp = take ? ax_disp[1] : m_v_disp;

  nmp_judge #(
    .SPAN_W(SPAN_W),
    .MIN_H (MIN_H),
    .MIN_V (MIN_V)
  ) u_judge (
    .h_disp(nxt_h_disp),
    .v_disp(nxt_v_disp),
    .usable(nxt_usable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pclk       <= '0;
      m_h_disp     <= '0;
      m_h_ss       <= '0;
      m_h_se       <= '0;
      m_h_tot      <= '0;
      m_v_disp     <= '0;
      m_v_ss       <= '0;
      m_v_se       <= '0;
      m_v_tot      <= '0;
      m_pos_h      <= 1'b0;
      m_pos_v      <= 1'b0;
      m_ilace      <= 1'b0;
      done         <= 1'b0;
      result_valid <= 1'b0;
      error        <= 1'b0;
    end else begin
      done         <= 1'b0;
      result_valid <= 1'b0;
      error        <= 1'b0;
      if (start) begin
        m_pclk   <= '0;
        m_h_disp <= '0;
        m_h_ss   <= '0;
        m_h_se   <= '0;
        m_h_tot  <= '0;
        m_v_disp <= '0;
        m_v_ss   <= '0;
        m_v_se   <= '0;
        m_v_tot  <= '0;
        m_pos_h  <= 1'b0;
        m_pos_v  <= 1'b0;
        m_ilace  <= 1'b0;
      end else begin
        if (take) begin
          m_pclk   <= pclk_scaled;
          m_h_disp <= ax_disp[0];
          m_h_ss   <= ax_ss[0];
          m_h_se   <= ax_se[0];
          m_h_tot  <= ax_tot[0];
          m_v_disp <= ax_disp[1];
          m_v_ss   <= ax_ss[1];
          m_v_se   <= ax_se[1];
          m_v_tot  <= ax_tot[1];
          m_pos_h  <= cand_flags.pos_h;
          m_pos_v  <= cand_flags.pos_v;
          m_ilace  <= cand_flags.ilace;
        end
        if (beat && d_last) begin
          done         <= 1'b1;
          result_valid <= nxt_usable;
          error        <= !nxt_usable;
        end
      end
    end
  end
endmodule

// File: rtl/nmp_checker.sv
module nmp_checker #(
  parameter int ACT_W  = 12,
  parameter int PCLK_W = 16,
  parameter int MIN_H  = 640,
  parameter int MIN_V  = 480
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     d_valid,
  input logic                     d_ready,
  input logic                     d_last,
  input logic signed [PCLK_W-1:0] d_pclk,
  input logic [ACT_W+1:0]         m_h_disp,
  input logic [ACT_W+1:0]         m_v_disp,
  input logic                     done,
  input logic                     result_valid,
  input logic                     error
);
  localparam int SPAN_W = ACT_W + 2;

  logic acc;
  assign acc = d_valid && d_ready;

  p_ready_low_in_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !d_ready);

  p_cleared_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (m_h_disp == '0) && (m_v_disp == '0));

  p_done_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && d_last) |=> done);

  p_done_needs_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(acc && d_last));

  p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({result_valid, error}) == 1));

  p_no_verdict_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!result_valid && !error));

  p_valid_meets_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (m_h_disp >= SPAN_W'(MIN_H)) && (m_v_disp >= SPAN_W'(MIN_V)));

  p_width_never_shrinks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (m_h_disp >= $past(m_h_disp)));

  p_bad_clock_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (d_pclk <= 0)) |=> ($stable(m_h_disp) && $stable(m_v_disp)));
endmodule

bind native_mode_pick nmp_checker #(
  .ACT_W (ACT_W),
  .PCLK_W(PCLK_W),
  .MIN_H (MIN_H),
  .MIN_V (MIN_V)
) u_nmp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .d_valid     (d_valid),
  .d_ready     (d_ready),
  .d_last      (d_last),
  .d_pclk      (d_pclk),
  .m_h_disp    (m_h_disp),
  .m_v_disp    (m_v_disp),
  .done        (done),
  .result_valid(result_valid),
  .error       (error)
);

// File: tb/test_native_mode_pick.sv
module test_native_mode_pick;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic d_valid = 1'b0;
  logic d_ready;
  logic d_last = 1'b0;
  logic signed [15:0] d_pclk = '0;
  logic [11:0] d_h_act = '0, d_h_blank = '0, d_v_act = '0, d_v_blank = '0;
  logic [9:0]  d_h_soff = '0, d_h_swid = '0, d_v_soff = '0, d_v_swid = '0;
  logic [1:0]  d_sync_kind = '0, d_misc = '0;
  logic        d_ilace = 1'b0;
  logic [19:0] m_pclk;
  logic [13:0] m_h_disp, m_h_ss, m_h_se, m_h_tot, m_v_disp, m_v_ss, m_v_se, m_v_tot;
  logic        m_pos_h, m_pos_v, m_ilace, done, result_valid, error;

  always #2 clk = ~clk;

  native_mode_pick i_native_mode_pick (
    .clk(clk), .rst_n(rst_n), .start(start), .d_valid(d_valid), .d_ready(d_ready),
    .d_last(d_last), .d_pclk(d_pclk), .d_h_act(d_h_act), .d_h_blank(d_h_blank),
    .d_h_soff(d_h_soff), .d_h_swid(d_h_swid), .d_v_act(d_v_act), .d_v_blank(d_v_blank),
    .d_v_soff(d_v_soff), .d_v_swid(d_v_swid), .d_sync_kind(d_sync_kind), .d_misc(d_misc),
    .d_ilace(d_ilace), .m_pclk(m_pclk), .m_h_disp(m_h_disp), .m_h_ss(m_h_ss),
    .m_h_se(m_h_se), .m_h_tot(m_h_tot), .m_v_disp(m_v_disp), .m_v_ss(m_v_ss),
    .m_v_se(m_v_se), .m_v_tot(m_v_tot), .m_pos_h(m_pos_h), .m_pos_v(m_pos_v),
    .m_ilace(m_ilace), .done(done), .result_valid(result_valid), .error(error)
  );

  typedef struct {
    longint pclk;
    longint hd, hss, hse, ht, vd, vss, vse, vt;
    bit ph, pv, il, ok;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic exp_t cleared();
    exp_t e;
    e.pclk = 0; e.hd = 0; e.hss = 0; e.hse = 0; e.ht = 0;
    e.vd = 0; e.vss = 0; e.vse = 0; e.vt = 0;
    e.ph = 0; e.pv = 0; e.il = 0; e.ok = 0;
    return e;
  endfunction

  // R8: start blocks the input and clears the kept mode
  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    #1 chk("R8 d_ready during start", longint'(d_ready), 0);
    @(negedge clk);
    start = 1'b0;
    chk("R8 h display cleared", longint'(m_h_disp), 0);
    chk("R8 pclk cleared", longint'(m_pclk), 0);
    cur = cleared();
  endtask

  // driver: one beat, updating the reference model from the requirements
  task automatic send(input int pclk, input int ha, input int hb, input int hso, input int hsw,
                      input int va, input int vb, input int vso, input int vsw,
                      input int sk, input int mi, input int il, input bit last);
    @(negedge clk);
    d_valid = 1'b1; d_last = last; d_pclk = 16'(pclk);
    d_h_act = 12'(ha); d_h_blank = 12'(hb); d_h_soff = 10'(hso); d_h_swid = 10'(hsw);
    d_v_act = 12'(va); d_v_blank = 12'(vb); d_v_soff = 10'(vso); d_v_swid = 10'(vsw);
    d_sync_kind = 2'(sk); d_misc = 2'(mi); d_ilace = il[0];
    if (pclk > 0 && ha > cur.hd) begin
      cur.pclk = longint'(pclk) * 10;
      cur.hd = ha; cur.hss = ha + hso; cur.hse = ha + hso + hsw; cur.ht = ha + hb;
      cur.vd = va; cur.vss = va + vso; cur.vse = va + vso + vsw; cur.vt = va + vb;
      cur.ph = (sk == 3) && mi[0];
      cur.pv = (sk == 3) && mi[1];
      cur.il = il[0];
    end
    if (last) begin
      cur.ok = (cur.hd != 0) && (cur.hd >= 640) && (cur.vd >= 480);
      exp_q.push_back(cur);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    d_valid = 1'b0; d_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop the expected verdict when done shows up
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R7 result_valid", longint'(result_valid), longint'(e.ok));
        chk("R7 error", longint'(error), longint'(!e.ok));
        chk("R4 pclk x10", longint'(m_pclk), e.pclk);
        chk("R2 h display", longint'(m_h_disp), e.hd);
        chk("R2 v display", longint'(m_v_disp), e.vd);
        chk("R3 h sync start", longint'(m_h_ss), e.hss);
        chk("R3 h sync end", longint'(m_h_se), e.hse);
        chk("R3 h total", longint'(m_h_tot), e.ht);
        chk("R3 v sync start", longint'(m_v_ss), e.vss);
        chk("R3 v sync end", longint'(m_v_se), e.vse);
        chk("R3 v total", longint'(m_v_tot), e.vt);
        chk("R5 pos hsync", longint'(m_pos_h), longint'(e.ph));
        chk("R5 pos vsync", longint'(m_pos_v), longint'(e.pv));
        chk("R6 interlace", longint'(m_ilace), longint'(e.il));
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    cur = cleared();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 d_ready", longint'(d_ready), 1);
    chk("R9 done", longint'(done), 0);
    chk("R9 result_valid", longint'(result_valid), 0);
    chk("R9 error", longint'(error), 0);
    chk("R9 h display", longint'(m_h_disp), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // rising widths, back to back; kind 3 with both polarity bits (R2 R3 R4 R5)
    do_start();
    send(1000,  800, 256, 40, 128,  600, 28, 1, 4, 3, 1, 0, 0);
    send(2000, 1024, 320, 24, 136,  768, 38, 3, 6, 3, 2, 1, 0);
    send(1500, 1280, 400, 48, 112, 1024, 42, 1, 3, 3, 3, 0, 1);
    idle(3);

    // equal width with other height, then a narrower one; kind 2 (R2 R5 R6)
    do_start();
    send( 500, 1024, 300, 20, 100,  768, 30, 2, 5, 2, 3, 1, 0);
    send( 900, 1024, 310, 22, 102, 1200, 31, 3, 7, 3, 3, 0, 0);
    send( 700,  900, 200, 10,  50, 2000, 20, 1, 2, 3, 3, 0, 1);
    idle(3);

    // wider beats with zero and negative clocks are skipped (R1)
    do_start();
    send( 800,  700, 100, 16,  64,  500, 20, 2, 2, 3, 2, 0, 0);
    send(   0, 1920, 280, 88,  44, 1080, 45, 4, 5, 3, 3, 1, 0);
    send(  -3, 1600, 160, 48,  32, 1200, 35, 3, 6, 3, 1, 1, 1);
    idle(3);

    // nothing kept: error (R1 R7)
    do_start();
    send(   0, 1024, 320, 24, 136,  768, 38, 3, 6, 3, 3, 1, 1);
    idle(3);

    // below the floor horizontally, then vertically (R7)
    do_start();
    send( 100,  600, 100, 10,  20,  480, 10, 1, 1, 3, 1, 0, 1);
    idle(2);
    do_start();
    send( 100,  640, 100, 10,  20,  479, 10, 1, 1, 0, 3, 0, 1);
    idle(2);

    // exactly at the floor, largest clock, kind 3 with no polarity bits (R4 R5 R7)
    do_start();
    send(32767, 640, 160, 16,  96,  480, 45, 10, 2, 3, 0, 0, 1);
    idle(4);

    chk("R7 all verdicts seen", longint'(exp_q.size()), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule